// File: doc/BRIEF.md
# Byte-Parity Protected Entry Memory

This block is a synchronous single-port memory of 64-bit entries with one parity bit per data byte. On a write it derives eight even-parity bits from the incoming word and stores them next to the data. On a read it returns the stored word one cycle later. In that same cycle it derives parity again from the stored data and compares it, lane by lane, with the stored bits. Any disagreement is reported in two ways. A one-cycle external-error pulse goes to the processor that owns the memory. A latched interrupt goes to the host and holds the address of the first failing read until software clears it.

A per-read byte-lane mask shows which lanes disagreed. A test-only injection input inverts one chosen stored parity bit during a write, so parity faults can be provoked on purpose. The block does no correction and no scrubbing. The asynchronous active-low reset is released synchronously inside the block, so the first access may be made three clock edges after reset is removed.

Top module: `parity_entry_mem`

## Requirements
- R1: A read request (`req_valid`=1, `req_we`=0) returns the word last written to that address on `rd_data`, with `rd_valid`=1, in the cycle after the request.
- R2: `rd_valid` is 1 only in the cycle after a read request. A write request (`req_we`=1) or an idle cycle gives `rd_valid`=0 in the following cycle.
- R3: Each stored parity bit i is the even parity (XOR) of data bits [8i+7:8i]. For an entry written without injection, a read returns `rd_lane_err`=0.
- R4: A write with `inj_en`=1 stores parity bit `inj_lane` inverted. A later read of that entry returns `rd_lane_err` equal to 1 shifted left by `inj_lane`, and the correct data.
- R5: `rd_lane_err` is all zero in every cycle where `rd_valid` is 0.
- R6: `cop_err_pulse` is 1 exactly in the `rd_valid` cycles where `rd_lane_err` is nonzero.
- R7: When `host_irq` is 0, a `cop_err_pulse` cycle sets `host_irq` at the next edge and loads `host_irq_addr` with the address of that read.
- R8: While `host_irq` is 1 and no clear is given, later errors leave `host_irq_addr` unchanged.
- R9: `irq_clr`=1 drops `host_irq` at the next edge. If an error pulse falls in the same cycle, `host_irq` stays 1 and `host_irq_addr` takes the address of the new failing read.
- R10: After reset, `rd_valid`, `cop_err_pulse` and `host_irq` are 0, `rd_lane_err` is 0 and `host_irq_addr` is 0.
- R11: Rewriting an entry without injection removes its parity error for later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Entry address |
| req_wdata | input | DATA_W | Write data |
| inj_en | input | 1 | Test only: invert one parity bit on this write |
| inj_lane | input | $clog2(DATA_W/8) | Lane whose parity bit is inverted |
| irq_clr | input | 1 | Clears the host interrupt |
| rd_valid | output | 1 | Read data and check are valid |
| rd_data | output | DATA_W | Read data |
| rd_lane_err | output | DATA_W/8 | Lanes whose parity disagreed on this read |
| cop_err_pulse | output | 1 | One-cycle error toward the owning processor |
| host_irq | output | 1 | Sticky interrupt toward the host |
| host_irq_addr | output | ADDR_W | Address of the first failing read |

## Verification
A corrupted stored parity bit or a wrong lane split shows on `rd_lane_err` in the cycle right after the read of the affected entry, and that is where the lane mask is compared. A fault in the interrupt latch shows one edge later, as a wrong `host_irq` level or a wrong captured address. The bench therefore reads the interrupt state after each error and after each clear. A stuck read-valid register shows as a visible `rd_valid` level after writes and idle cycles, not only after reads.

// File: rtl/parity_mem_pkg.sv
package parity_mem_pkg;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pm_lane_parity.sv
module pm_lane_parity
  import parity_mem_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned LANES = DATA_W / BYTE_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  par
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign par[g] = ^data[g*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/pm_entry_store.sv
module pm_entry_store #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANES  = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  wpar,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [LANES-1:0]  rd_par,
  output logic [ADDR_W-1:0] rd_addr
);
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [LANES-1:0]  par_mem  [DEPTH];
  logic              rd_valid_d;

  // storage, clock-enabled by write
  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_mem[addr] <= wdata;
      par_mem[addr]  <= wpar;
    end
  end

  // read capture, clock-enabled by read
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= data_mem[addr];
      rd_par  <= par_mem[addr];
      rd_addr <= addr;
    end
  end

  always_comb rd_valid_d = rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_valid_d;
  end
endmodule

// File: rtl/pm_err_notify.sv
module pm_err_notify #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              clr,
  output logic              irq,
  output logic [ADDR_W-1:0] irq_addr
);
  logic              irq_d;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    irq_d   = irq;
    addr_d  = irq_addr;
    addr_en = 1'b0;
    if (err && (!irq || clr)) begin
      irq_d   = 1'b1;
      addr_d  = err_addr;
      addr_en = 1'b1;
    end else if (clr) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      irq_addr <= '0;
    end else begin
      irq <= irq_d;
      if (addr_en) irq_addr <= addr_d;
    end
  end
endmodule

// File: rtl/parity_entry_mem.sv
module parity_entry_mem
  import parity_mem_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned LANES  = DATA_W / BYTE_W,
  localparam int unsigned LIDX_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              inj_en,
  input  logic [LIDX_W-1:0] inj_lane,
  input  logic              irq_clr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [LANES-1:0]  rd_lane_err,
  output logic              cop_err_pulse,
  output logic              host_irq,
  output logic [ADDR_W-1:0] host_irq_addr
);
  logic              rst_sync_n;
  logic              wr_en, rd_en;
  logic [LANES-1:0]  wr_par_calc, inj_mask, wr_par;
  logic [LANES-1:0]  rd_par_q, rd_par_calc;
  logic [ADDR_W-1:0] rd_addr_q;

  pm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign wr_en = req_valid &  req_we;
  assign rd_en = req_valid & ~req_we;

  pm_lane_parity #(.DATA_W(DATA_W)) u_wpar (.data(req_wdata), .par(wr_par_calc));

  always_comb begin
    inj_mask = '0;
    if (inj_en) inj_mask[inj_lane] = 1'b1;
    wr_par = wr_par_calc ^ inj_mask;
  end

  pm_entry_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(req_addr), .wdata(req_wdata), .wpar(wr_par),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_par(rd_par_q), .rd_addr(rd_addr_q)
  );

  pm_lane_parity #(.DATA_W(DATA_W)) u_rpar (.data(rd_data), .par(rd_par_calc));

  assign rd_lane_err   = rd_valid ? (rd_par_calc ^ rd_par_q) : '0;
  assign cop_err_pulse = rd_valid & (|rd_lane_err);

  pm_err_notify #(.ADDR_W(ADDR_W)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .err(cop_err_pulse), .err_addr(rd_addr_q),
    .clr(irq_clr), .irq(host_irq), .irq_addr(host_irq_addr)
  );
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LANES  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_we,
  input logic              irq_clr,
  input logic              rd_valid,
  input logic [LANES-1:0]  rd_lane_err,
  input logic              cop_err_pulse,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              host_irq,
  input logic [ADDR_W-1:0] host_irq_addr
);
  AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rd_valid); // R1
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rd_valid); // R2
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_lane_err == '0)); // R5
  AST_PULSE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    cop_err_pulse |-> rd_valid); // R6
  AST_PULSE_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_lane_err != '0) |-> cop_err_pulse); // R6
  AST_IRQ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_err_pulse && !host_irq) |=> (host_irq && host_irq_addr == $past(rd_addr))); // R7
  AST_IRQ_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && !irq_clr) |=> (host_irq && $stable(host_irq_addr))); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !cop_err_pulse) |=> !host_irq); // R9
endmodule

bind parity_entry_mem pm_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_we(req_we),
  .irq_clr(irq_clr), .rd_valid(rd_valid), .rd_lane_err(rd_lane_err),
  .cop_err_pulse(cop_err_pulse), .rd_addr(rd_addr_q),
  .host_irq(host_irq), .host_irq_addr(host_irq_addr)
);

// File: tb/parity_entry_mem_tb.sv
module parity_entry_mem_tb;
  localparam int AW = 4;
  localparam int DW = 64;
  localparam int LN = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_we, inj_en, irq_clr;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [2:0]    inj_lane;
  logic          rd_valid, cop_err_pulse, host_irq;
  logic [DW-1:0] rd_data;
  logic [LN-1:0] rd_lane_err;
  logic [AW-1:0] host_irq_addr;

  int vec_cnt = 0;
  int bad_cnt = 0;

  always #5 clk = ~clk;

  parity_entry_mem #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .inj_en(inj_en),
    .inj_lane(inj_lane), .irq_clr(irq_clr), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_lane_err(rd_lane_err), .cop_err_pulse(cop_err_pulse),
    .host_irq(host_irq), .host_irq_addr(host_irq_addr)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return {8{8'(a * 37 + 5)}} ^ (64'h1 << (a * 4)) ^ 64'hF0E1_D2C3_B4A5_9687;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    vec_cnt++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_we = 1'b0; inj_en = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d, input bit inj, input int lane);
    req_valid = 1'b1; req_we = 1'b1; req_addr = AW'(a); req_wdata = d;
    inj_en = inj; inj_lane = 3'(lane);
    @(posedge clk); @(negedge clk);
    idle();
    chk(rd_valid == 1'b0, "R2 write gives no rd_valid", 64'(rd_valid), 64'd0);
  endtask

  // leaves the bench at the negedge of the rd_valid cycle
  task automatic do_read(input int a, input logic [DW-1:0] d, input logic [LN-1:0] m,
                         input string req);
    req_valid = 1'b1; req_we = 1'b0; req_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    idle();
    chk(rd_valid == 1'b1, "R1 rd_valid", 64'(rd_valid), 64'd1);
    chk(rd_data == d, "R1 rd_data", rd_data, d);
    chk(rd_lane_err == m, req, 64'(rd_lane_err), 64'(m));
    chk(cop_err_pulse == (m != 0), "R6 cop_err_pulse", 64'(cop_err_pulse), 64'(m != 0));
  endtask

  task automatic step_check_irq(input bit e_irq, input int e_addr, input string req);
    @(posedge clk); @(negedge clk);
    chk(host_irq == e_irq, req, 64'(host_irq), 64'(e_irq));
    if (e_irq) chk(host_irq_addr == AW'(e_addr), req, 64'(host_irq_addr), 64'(e_addr));
    chk(rd_valid == 1'b0 && rd_lane_err == 0 && cop_err_pulse == 0,
        "R5 idle outputs quiet", 64'(rd_lane_err), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad_cnt++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    idle(); req_addr = '0; req_wdata = '0; inj_lane = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(rd_valid == 0 && cop_err_pulse == 0 && host_irq == 0 && rd_lane_err == 0,
        "R10 reset flags", {rd_valid, cop_err_pulse, host_irq}, 64'd0);
    chk(host_irq_addr == 0, "R10 reset addr", 64'(host_irq_addr), 64'd0);

    // R1/R3 clean fill and readback over every entry
    for (int a = 0; a < (1 << AW); a++) do_write(a, pat(a), 1'b0, 0);
    for (int a = 0; a < (1 << AW); a++) do_read(a, pat(a), '0, "R3 clean mask");
    step_check_irq(1'b0, 0, "R3 no irq on clean reads");

    // R4 injection on each lane; R7 first capture, R8 hold
    for (int l = 0; l < LN; l++) begin
      do_write(l + 2, ~pat(l + 2), 1'b1, l);
      do_read(l + 2, ~pat(l + 2), LN'(1) << l, "R4 injected lane mask");
      if (l == 0) step_check_irq(1'b1, 2, "R7 irq capture");
      else        step_check_irq(1'b1, 2, "R8 irq address held");
    end

    // R11 rewrite clears the error
    do_write(3, pat(3), 1'b0, 0);
    do_read(3, pat(3), '0, "R11 rewrite clears");

    // R9 plain clear
    irq_clr = 1'b1;
    step_check_irq(1'b0, 0, "R9 clear drops irq");
    irq_clr = 1'b0;

    // R7 recapture at new address
    do_read(4, ~pat(4), LN'(1) << 2, "R4 lane2 mask");
    step_check_irq(1'b1, 4, "R7 recapture");

    // R9 clear coinciding with an error: new address wins
    do_read(5, ~pat(5), LN'(1) << 3, "R4 lane3 mask");
    irq_clr = 1'b1;
    step_check_irq(1'b1, 5, "R9 clear with error");
    irq_clr = 1'b0;
    step_check_irq(1'b1, 5, "R8 hold after recapture");

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end
endmodule